// File: doc/BRIEF.md
# Ping-Pong Staging Write Channel

This block is one peripheral-to-memory channel that fills a staging RAM in a circular ping-pong pattern. The staging RAM is split into two equal halves. Half 0 starts at `cfgBase`. Half 1 starts right after it, at `cfgBase + cfgCount * DATA_W/8`. The channel takes data beats from a peripheral over a valid/ready handshake and writes each beat, as one full-width word, to a plain SRAM write port. The addresses rise through the half currently selected.

A down-counter follows the items left in the current half. When the last item of a half is written, three things happen with no outside help: the channel moves to the other half, reloads the count and keeps running. For each half it keeps a sticky completion flag, and it emits a one-cycle completion pulse. A second engine can use that pulse to drain the half just filled while the other half is being filled.

The flags stay set until an external bus write to the clear port removes them, bit by bit, under a mask. The channel stops only when `enable` is dropped. `pause` holds it in place and also reports a completion event. `cfgCount` must be nonzero while the channel is enabled.

Top module: `pp_dma_chan`

## Requirements
- R1: While `rstN` is low and in the first cycle after it, `inReady`, `memWe`, `tcPulse`, `curBuf` and `tcFlags` are all 0.
- R2: A beat is accepted when `inValid` and `inReady` are both high. In that same cycle `memWe` is 1, `memWdata` equals `inData` and every bit of `memStrb` is 1. When no beat is accepted, `memWe` is 0.
- R3: Inside a half, each accepted beat is written `DATA_W/8` bytes above the previous one. The first beat after `enable` rises goes to `cfgBase`.
- R4: After `cfgCount` beats the channel swaps halves and `curBuf` toggles. The next beat goes to the start of the other half: `cfgBase` for half 0 and `cfgBase + cfgCount*DATA_W/8` for half 1. The count reloads and acceptance continues with no gap, for as many periods as beats arrive.
- R5: The cycle after the edge that accepts the last beat of a half, `tcPulse` is 1 for one cycle. In that same cycle the flag bit of the half just filled (`tcFlags[0]` for half 0, `tcFlags[1]` for half 1) is set, and `curBuf` already shows the new half.
- R6: While `pause` is high, `inReady` is 0. A rise of `pause` on a running channel gives a `tcPulse` and sets the flag bit of the current half, with no swap. After `pause` falls, writing resumes at the same address with the count unchanged.
- R7: A cycle with `clrWe` high clears exactly those `tcFlags` bits whose `clrMask` bit is 1. All other bits keep their value.
- R8: If a clear and a new completion on the same bit fall in one cycle, that bit ends up set.
- R9: With `enable` low, `inReady` is 0 in that cycle and the flags are kept. A later rise of `enable` restarts at half 0, at `cfgBase`, with the full count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Channel run control |
| pause | input | 1 | Hold transfers; its rise reports completion |
| cfgBase | input | ADDR_W | Byte address of the start of half 0 |
| cfgCount | input | CNT_W | Items per half (nonzero) |
| inValid | input | 1 | Peripheral beat present |
| inData | input | DATA_W | Peripheral beat data |
| inReady | output | 1 | Channel takes the beat this cycle |
| memWe | output | 1 | SRAM write enable |
| memAddr | output | ADDR_W | SRAM byte address |
| memWdata | output | DATA_W | SRAM write data |
| memStrb | output | DATA_W/8 | SRAM byte strobes |
| clrWe | input | 1 | Clear-register write strobe |
| clrMask | input | 2 | Bits of `tcFlags` to clear |
| tcFlags | output | 2 | Sticky completion flag per half |
| tcPulse | output | 1 | One-cycle completion trigger |
| curBuf | output | 1 | Half currently being filled |

## Verification
Two events can land on the same edge: the last beat of a half, which sets a flag, and a bus write to the clear register, which clears flags. The bench raises the clear strobe with a full mask in exactly the cycle that carries the final beat, and it also sweeps clear masks across every phase of the count. In each case it expects the bit of the half just filled to survive and every other masked bit to drop. Pause rises are placed between beats and checked the same way, since they also set a flag.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
  localparam int NBUF = 2;

  typedef struct packed {
    logic start;
    logic accept;
    logic step;
    logic swap;
    logic nextBuf;
  } ppStrobe_t;
endpackage

// File: rtl/pp_dma_ctrl.sv
module pp_dma_ctrl
  import pp_dma_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             pause,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic             inValid,
  input  logic             clrWe,
  input  logic [NBUF-1:0]  clrMask,
  output logic             inReady,
  output ppStrobe_t        strobes,
  output logic [NBUF-1:0]  tcFlags,
  output logic             tcPulse,
  output logic             curBuf
);
  logic             running;
  logic             pauseQ;
  logic [CNT_W-1:0] itemsLeft;
  logic             accept;
  logic             lastBeat;
  logic             pauseEdge;
  logic             tcEvent;

  assign inReady   = running & enable & ~pause;
  assign accept    = inValid & inReady;
  assign lastBeat  = accept & (itemsLeft == CNT_W'(1));
  assign pauseEdge = running & pause & ~pauseQ;
  assign tcEvent   = lastBeat | pauseEdge;

  always_comb begin
    strobes         = '0;
    strobes.start   = enable & ~running;
    strobes.accept  = accept;
    strobes.step    = accept & ~lastBeat;
    strobes.swap    = lastBeat;
    strobes.nextBuf = ~curBuf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      pauseQ    <= 1'b0;
      tcPulse   <= 1'b0;
      itemsLeft <= '0;
      curBuf    <= 1'b0;
    end else begin
      running <= enable;
      pauseQ  <= pause;
      tcPulse <= tcEvent;
      if (strobes.start) begin
        itemsLeft <= cfgCount;
        curBuf    <= 1'b0;
      end else if (lastBeat) begin
        itemsLeft <= cfgCount;
        curBuf    <= ~curBuf;
      end else if (accept) begin
        itemsLeft <= itemsLeft - CNT_W'(1);
      end
    end
  end

  for (genvar b = 0; b < NBUF; b++) begin : g_flag
    logic setHere;
    logic clrHere;
    assign setHere = tcEvent & (curBuf == b[0]);
    assign clrHere = clrWe & clrMask[b];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        tcFlags[b] <= 1'b0;
      else if (setHere) tcFlags[b] <= 1'b1;
      else if (clrHere) tcFlags[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/pp_dma_dp.sv
module pp_dma_dp
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ppStrobe_t             strobes,
  input  logic [ADDR_W-1:0]     cfgBase,
  input  logic [CNT_W-1:0]      cfgCount,
  input  logic [DATA_W-1:0]     inData,
  output logic                  memWe,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [DATA_W-1:0]     memWdata,
  output logic [DATA_W/8-1:0]   memStrb
);
  localparam int BYTES = DATA_W / 8;

  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] halfBase;
  logic [ADDR_W-1:0] nextBase;

  assign halfBase = cfgBase + ADDR_W'(cfgCount) * ADDR_W'(BYTES);
  assign nextBase = strobes.nextBuf ? halfBase : cfgBase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              wrPtr <= '0;
    else if (strobes.start) wrPtr <= cfgBase;
    else if (strobes.swap)  wrPtr <= nextBase;
    else if (strobes.step)  wrPtr <= wrPtr + ADDR_W'(BYTES);
  end

  assign memWe    = strobes.accept;
  assign memAddr  = wrPtr;
  assign memWdata = inData;
  assign memStrb  = {BYTES{1'b1}};
endmodule

// File: rtl/pp_dma_chan.sv
module pp_dma_chan
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                pause,
  input  logic [ADDR_W-1:0]   cfgBase,
  input  logic [CNT_W-1:0]    cfgCount,
  input  logic                inValid,
  input  logic [DATA_W-1:0]   inData,
  output logic                inReady,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic [DATA_W/8-1:0] memStrb,
  input  logic                clrWe,
  input  logic [1:0]          clrMask,
  output logic [1:0]          tcFlags,
  output logic                tcPulse,
  output logic                curBuf
);
  ppStrobe_t strobes;

  pp_dma_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .pause(pause),
    .cfgCount(cfgCount), .inValid(inValid), .clrWe(clrWe), .clrMask(clrMask),
    .inReady(inReady), .strobes(strobes), .tcFlags(tcFlags),
    .tcPulse(tcPulse), .curBuf(curBuf)
  );

  pp_dma_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgBase(cfgBase),
    .cfgCount(cfgCount), .inData(inData), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memStrb(memStrb)
  );
endmodule

// File: rtl/pp_dma_chan_chk.sv
module pp_dma_chan_chk (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic       pause,
  input logic       inValid,
  input logic       inReady,
  input logic       memWe,
  input logic       clrWe,
  input logic [1:0] clrMask,
  input logic [1:0] tcFlags,
  input logic       tcPulse,
  input logic       curBuf
);
  p_we_handshake_r2: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (inValid && inReady));

  p_swap_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((curBuf != $past(curBuf)) && $past(inReady)) |-> tcPulse);

  p_flag_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(tcFlags[0]) || $rose(tcFlags[1])) |-> tcPulse);

  p_pause_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    pause |-> !inReady);

  p_clear_lo_r7: assert property (@(posedge clk) disable iff (!rstN)
    (clrWe && clrMask[0]) |=> (!tcFlags[0] || tcPulse));

  p_clear_hi_r7: assert property (@(posedge clk) disable iff (!rstN)
    (clrWe && clrMask[1]) |=> (!tcFlags[1] || tcPulse));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    tcPulse |-> (tcFlags != 2'b00));

  p_disabled_r9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !inReady);
endmodule

bind pp_dma_chan pp_dma_chan_chk u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .pause(pause),
  .inValid(inValid), .inReady(inReady), .memWe(memWe), .clrWe(clrWe),
  .clrMask(clrMask), .tcFlags(tcFlags), .tcPulse(tcPulse), .curBuf(curBuf)
);

// File: tb/pp_dma_chan_bench.sv
`timescale 1ns/100ps
module pp_dma_chan_bench;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 8;
  localparam int BYTES  = DATA_W / 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              enable = 1'b0;
  logic              pause = 1'b0;
  logic [ADDR_W-1:0] cfgBase = 16'h0100;
  logic [CNT_W-1:0]  cfgCount = 8'd3;
  logic              inValid = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic              inReady;
  logic              memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic [BYTES-1:0]  memStrb;
  logic              clrWe = 1'b0;
  logic [1:0]        clrMask = 2'b00;
  logic [1:0]        tcFlags;
  logic              tcPulse;
  logic              curBuf;

  always #2.5 clk = ~clk;

  pp_dma_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_pp_dma_chan (
    .clk(clk), .rstN(rstN), .enable(enable), .pause(pause), .cfgBase(cfgBase),
    .cfgCount(cfgCount), .inValid(inValid), .inData(inData), .inReady(inReady),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memStrb(memStrb),
    .clrWe(clrWe), .clrMask(clrMask), .tcFlags(tcFlags), .tcPulse(tcPulse),
    .curBuf(curBuf)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // bench model state
  bit       mRun = 0, mBuf = 0, mPulse = 0, mPauseQ = 0;
  int       mIdx = 0;
  bit [1:0] mFlags = 0;
  int       beatNo = 0;

  task automatic chk(input bit ok, input string tag, input longint got, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cycle(input bit v, input bit p, input bit en, input bit cw, input bit [1:0] cm);
    bit rdy, acc, last, pe;
    bit [1:0] setm;
    longint expAddr;
    @(negedge clk);
    chk(tcPulse === mPulse, "R5 tcPulse", tcPulse, mPulse);
    chk(curBuf === mBuf, "R4 curBuf", curBuf, mBuf);
    chk(tcFlags === mFlags, "R7 tcFlags", tcFlags, mFlags);
    beatNo++;
    inValid = v; pause = p; enable = en; clrWe = cw; clrMask = cm;
    inData  = 32'hA5000000 ^ (beatNo * 32'h01010101);
    #1;
    rdy = en && !p && mRun;
    chk(inReady === rdy, p ? "R6 inReady" : (!en ? "R9 inReady" : "R2 inReady"), inReady, rdy);
    acc = v && rdy;
    chk(memWe === acc, "R2 memWe", memWe, acc);
    if (acc) begin
      expAddr = (longint'(cfgBase) + (mBuf ? longint'(cfgCount) * BYTES : 0) + mIdx * BYTES) & 16'hFFFF;
      chk(memAddr === ADDR_W'(expAddr), mIdx == 0 ? "R4 memAddr" : "R3 memAddr", memAddr, expAddr);
      chk(memWdata === inData && memStrb === '1, "R2 data/strb", memWdata, inData);
    end
    pe   = mRun && p && !mPauseQ;
    last = acc && (mIdx == int'(cfgCount) - 1);
    setm = (last || pe) ? (mBuf ? 2'b10 : 2'b01) : 2'b00;
    mFlags = (mFlags & ~(cw ? cm : 2'b00)) | setm;
    mPulse = last || pe;
    if (en && !mRun) begin mBuf = 0; mIdx = 0; end
    else if (last) begin mIdx = 0; mBuf = ~mBuf; end
    else if (acc) mIdx++;
    mRun = en; mPauseQ = p;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk({inReady, memWe, tcPulse, curBuf, tcFlags} === 6'b0, "R1 reset outputs",
        {inReady, memWe, tcPulse, curBuf, tcFlags}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk({inReady, memWe, tcPulse, curBuf, tcFlags} === 6'b0, "R1 after release",
        {inReady, memWe, tcPulse, curBuf, tcFlags}, 0);

    // sweep counts with varied valid, pause and clear patterns
    for (int c = 1; c <= 5; c++) begin
      cfgCount = CNT_W'(c);
      cfgBase  = ADDR_W'(16'h0100 + c * 16'h40);
      cycle(0, 0, 0, 1, 2'b11);
      for (int i = 0; i < 14 * c + 10; i++) begin
        bit v, p, cw;
        v  = ((i * 7 + c) % 3) != 0;
        p  = (i % 13 == 6) || (i % 13 == 7);
        cw = (i % 5 == 2);
        cycle(v, p, 1, cw, 2'(i % 4));
      end
    end

    // R8: clear with full mask on the final beat of a half
    cfgCount = 8'd2; cfgBase = 16'h0200;
    cycle(0, 0, 0, 1, 2'b11);
    cycle(0, 0, 1, 0, 2'b00);
    cycle(1, 0, 1, 0, 2'b00);
    cycle(1, 0, 1, 1, 2'b11);
    cycle(0, 0, 1, 0, 2'b00);
    chk(tcFlags === 2'b01, "R8 set wins over clear", tcFlags, 2'b01);
    cycle(1, 0, 1, 0, 2'b00);
    cycle(1, 0, 1, 1, 2'b11);
    cycle(0, 0, 1, 0, 2'b00);
    chk(tcFlags === 2'b10, "R8 set wins hi, lo cleared", tcFlags, 2'b10);

    // R9: disable mid-half, flags kept, restart at half 0
    cycle(1, 0, 1, 0, 2'b00);
    cycle(1, 0, 0, 0, 2'b00);
    cycle(1, 0, 0, 0, 2'b00);
    chk(tcFlags === 2'b10, "R9 flags kept while disabled", tcFlags, 2'b10);
    for (int i = 0; i < 8; i++) cycle(1, 0, 1, 0, 2'b00);

    // R6: long pause holds address and count
    cycle(1, 0, 1, 0, 2'b00);
    for (int i = 0; i < 4; i++) cycle(1, 1, 1, 0, 2'b00);
    for (int i = 0; i < 6; i++) cycle(1, 0, 1, 0, 2'b00);
    cycle(0, 0, 1, 0, 2'b00);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule